// File: doc/BRIEF.md
# Microstep Phase Translator

This block turns step and direction pulses into signed current setpoints for the two windings of a bipolar stepper motor. It tracks the electrical angle as a 5-bit index in 11.25-degree units, so one electrical turn is 32 positions. Winding A follows the cosine of the angle and winding B follows the sine. Each winding gets an 8-bit magnitude and a sign bit. Each winding also gets a hint that tells the current regulator to use mixed decay when that winding's current is falling.

The step resolution is full, half, quarter or eighth step, picked by a 2-bit mode input. The index stride follows the resolution, so the coarser modes only reach the angles they are allowed to use. The translator can be sent to its home angle (45 degrees) with a home request and also homes when it wakes from sleep. A drive-enable input gates the outputs without losing the position. All control inputs go through synchronizers of equal depth, so step, direction and mode stay aligned as long as the external setup and hold timing around the step edge is met.

The setpoint leaves the block as a held level qualified by `set_valid`. There is no ready input and no back-pressure. The motor cannot stall a step, so a consumer has to take the current level every cycle. After a step edge, the new value appears within four clock cycles.

Top module: `ustep_xlate`

## Requirements
- R1: While `rst_n` is low, `set_valid` is 0. After reset, with `drive_en`=1 and `sleep_n`=1, the index is at home (index 4, 45 degrees) and both windings read magnitude 180 with sign 0.
- R2: Index k stands for angle k*11.25 degrees. Winding A carries |cos| and winding B carries |sin|, coded as round(percent*2.55). The magnitudes from 0 to 90 degrees are 255, 250, 236, 212, 180, 142, 98, 50 and 0. The sign bit is 1 for a negative current and is never 1 when the magnitude is 0.
- R3: In eighth mode, each step adds 1 to the index when `dir_in`=1 and subtracts 1 when `dir_in`=0. The index wraps modulo 32.
- R4: An on-grid step moves the index by 2 in quarter mode and by 4 in half mode, with the same direction rule and wrap as R3.
- R5: In full mode the stride is 8, and after any step the index is 4, 12, 20 or 28. Both windings then read magnitude 180.
- R6: `mode_sel` selects the resolution: 2'b00 full, 2'b01 half, 2'b10 quarter, 2'b11 eighth.
- R7: If the index is off the grid of the current mode when a step arrives, that step moves the index to the nearest grid point instead of advancing. When two grid points are equally near, it moves toward `dir_in`.
- R8: While `home_in`=1, the index is held at home and step edges have no effect.
- R9: While `sleep_n`=0, `set_valid` is 0. When `sleep_n` rises, the index returns to home.
- R10: While `drive_en`=0, `set_valid` is 0 and all magnitude and sign outputs are 0. Steps still move the index, and the setpoint for the tracked index reappears once `drive_en`=1.
- R11: On each index change, a winding's decay output becomes 1 (mixed) if its magnitude decreased and 0 (slow) otherwise. The output holds until the next index change.
- R12: Only a rising edge of `step_in` advances the index. Holding the step high or letting it fall causes no further change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_in | input | 1 | Step pulse; rising edge advances |
| dir_in | input | 1 | 1 = forward, 0 = reverse |
| mode_sel | input | 2 | Resolution select (R6) |
| home_in | input | 1 | Hold at home angle while high |
| sleep_n | input | 1 | Low = sleep; rising edge homes |
| drive_en | input | 1 | Output gate; high enables |
| a_mag | output | 8 | Winding A magnitude |
| a_neg | output | 1 | Winding A sign (1 = negative) |
| b_mag | output | 8 | Winding B magnitude |
| b_neg | output | 1 | Winding B sign (1 = negative) |
| a_mixed | output | 1 | Winding A decay hint (1 = mixed) |
| b_mixed | output | 1 | Winding B decay hint (1 = mixed) |
| set_valid | output | 1 | Setpoint qualifier |

## Verification
Some properties are checked by assertions on every cycle:
- the index sits on the 45-degree-offset grid after a full-mode step;
- quarter-mode steps land on even positions;
- an eighth-mode forward step adds exactly one;
- the index holds without a step edge, and a home request pins it;
- the output gate drops `set_valid`;
- decay hints hold between index changes;
- a zero magnitude never carries a negative sign.

Other behaviour can only be shown by the bench's scenarios:
- the actual magnitude and sign values around the circle;
- the nearest-point snap with its tie-breaking;
- wrap-around in both directions;
- the decay decisions themselves;
- tracking while disabled;
- homing on wake.

// File: rtl/ustep_pkg.sv
package ustep_pkg;
  localparam int IDX_W = 5;
  localparam int MAG_W = 8;
  localparam logic [IDX_W-1:0] HOME_IDX = 5'd4;
  localparam logic [IDX_W-1:0] QTR_TURN = 5'd8;
  localparam logic [IDX_W-1:0] SIN_SHIFT = 5'd24;

  typedef enum logic [1:0] {
    RES_FULL    = 2'b00,
    RES_HALF    = 2'b01,
    RES_QUARTER = 2'b10,
    RES_EIGHTH  = 2'b11
  } res_e;

  typedef struct packed {
    logic             neg;
    logic [MAG_W-1:0] mag;
  } phase_t;

  // magnitude for 0..8 eighth-steps away from a cosine peak
  function automatic logic [MAG_W-1:0] oct_mag(input logic [3:0] m);
    case (m)
      4'd0:    oct_mag = 8'd255;
      4'd1:    oct_mag = 8'd250;
      4'd2:    oct_mag = 8'd236;
      4'd3:    oct_mag = 8'd212;
      4'd4:    oct_mag = 8'd180;
      4'd5:    oct_mag = 8'd142;
      4'd6:    oct_mag = 8'd98;
      4'd7:    oct_mag = 8'd50;
      default: oct_mag = 8'd0;
    endcase
  endfunction

  function automatic phase_t cos_phase(input logic [IDX_W-1:0] k);
    logic [3:0] r;
    logic [3:0] m;
    phase_t     p;
    r = k[3:0];
    m = (r <= 4'd8) ? r : (4'd0 - r);
    p.mag = oct_mag(m);
    p.neg = (k > QTR_TURN) && (k < SIN_SHIFT);
    return p;
  endfunction
endpackage

// File: rtl/ustep_sync.sv
module ustep_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ustep_index.sv
module ustep_index import ustep_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_rise,
  input  logic             dir,
  input  res_e             mode,
  input  logic             home,
  input  logic             wake,
  output logic [IDX_W-1:0] idx,
  output logic             moved
);
  logic [IDX_W-1:0] pitch, origin, off, nxt;
  logic [IDX_W:0]   off2, pitch_x;

  always_comb begin
    case (mode)
      RES_FULL:    begin pitch = 5'd8; origin = HOME_IDX; end
      RES_HALF:    begin pitch = 5'd4; origin = 5'd0;     end
      RES_QUARTER: begin pitch = 5'd2; origin = 5'd0;     end
      default:     begin pitch = 5'd1; origin = 5'd0;     end
    endcase
    off     = (idx - origin) & (pitch - 5'd1);
    off2    = {off, 1'b0};
    pitch_x = {1'b0, pitch};
    if (off == '0)
      nxt = dir ? idx + pitch : idx - pitch;
    else if (off2 < pitch_x)
      nxt = idx - off;
    else if (off2 > pitch_x)
      nxt = idx + (pitch - off);
    else
      nxt = dir ? idx + (pitch - off) : idx - off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= HOME_IDX;
      moved <= 1'b0;
    end else if (home || wake) begin
      idx   <= HOME_IDX;
      moved <= 1'b1;
    end else if (step_rise) begin
      idx   <= nxt;
      moved <= 1'b1;
    end else begin
      moved <= 1'b0;
    end
  end

  // R8
  home_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    home |=> idx == HOME_IDX);
  // R5
  full_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_rise && !home && !wake && mode == RES_FULL) |=> idx[2:0] == 3'd4);
  // R4
  quarter_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_rise && !home && !wake && mode == RES_QUARTER) |=> !idx[0]);
  // R3
  eighth_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_rise && !home && !wake && mode == RES_EIGHTH && dir)
      |=> idx == $past(idx) + 5'd1);
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_rise && !home && !wake) |=> $stable(idx));
endmodule

// File: rtl/ustep_phase_lut.sv
module ustep_phase_lut import ustep_pkg::*; (
  input  logic [IDX_W-1:0] idx,
  output phase_t           ph_a,
  output phase_t           ph_b
);
  localparam logic [IDX_W-1:0] SHIFTS [2] = '{5'd0, SIN_SHIFT};
  phase_t ph [2];

  for (genvar g = 0; g < 2; g++) begin : g_wind
    always_comb ph[g] = cos_phase(idx + SHIFTS[g]);
  end

  assign ph_a = ph[0];
  assign ph_b = ph[1];
endmodule

// File: rtl/ustep_outstage.sv
module ustep_outstage import ustep_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t a_new,
  input  phase_t b_new,
  input  logic   moved,
  input  logic   gate_on,
  output phase_t a_q,
  output phase_t b_q,
  output logic   a_mix,
  output logic   b_mix,
  output logic   valid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= cos_phase(HOME_IDX);
      b_q     <= cos_phase(HOME_IDX + SIN_SHIFT);
      a_mix   <= 1'b0;
      b_mix   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      a_q     <= a_new;
      b_q     <= b_new;
      valid_q <= gate_on;
      if (moved) begin
        a_mix <= a_new.mag < a_q.mag;
        b_mix <= b_new.mag < b_q.mag;
      end
    end
  end

  // R10
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_on |=> !valid_q);
  // R11
  hint_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !moved |=> ($stable(a_mix) && $stable(b_mix)));
endmodule

// File: rtl/ustep_xlate.sv
module ustep_xlate import ustep_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_in,
  input  logic             dir_in,
  input  logic [1:0]       mode_sel,
  input  logic             home_in,
  input  logic             sleep_n,
  input  logic             drive_en,
  output logic [MAG_W-1:0] a_mag,
  output logic             a_neg,
  output logic [MAG_W-1:0] b_mag,
  output logic             b_neg,
  output logic             a_mixed,
  output logic             b_mixed,
  output logic             set_valid
);
  localparam int CTRL_W = 7;

  logic [CTRL_W-1:0] raw, synced;
  logic step_s, dir_s, home_s, sleep_s, en_s;
  logic [1:0] mode_s;
  logic step_d, sleep_d, step_rise, wake, moved;
  logic [IDX_W-1:0] idx;
  phase_t ph_a, ph_b, a_q, b_q;

  assign raw = {step_in, dir_in, mode_sel, home_in, sleep_n, drive_en};
  assign {step_s, dir_s, mode_s, home_s, sleep_s, en_s} = synced;

  ustep_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_d  <= 1'b0;
      sleep_d <= 1'b0;
    end else begin
      step_d  <= step_s;
      sleep_d <= sleep_s;
    end
  end

  assign step_rise = step_s && !step_d && sleep_s;
  assign wake      = sleep_s && !sleep_d;

  ustep_index u_index (
    .clk(clk), .rst_n(rst_n), .step_rise(step_rise), .dir(dir_s),
    .mode(res_e'(mode_s)), .home(home_s), .wake(wake),
    .idx(idx), .moved(moved));

  ustep_phase_lut u_lut (.idx(idx), .ph_a(ph_a), .ph_b(ph_b));

  ustep_outstage u_out (
    .clk(clk), .rst_n(rst_n), .a_new(ph_a), .b_new(ph_b), .moved(moved),
    .gate_on(en_s && sleep_s), .a_q(a_q), .b_q(b_q),
    .a_mix(a_mixed), .b_mix(b_mixed), .valid_q(set_valid));

  assign a_mag = set_valid ? a_q.mag : '0;
  assign a_neg = set_valid && a_q.neg;
  assign b_mag = set_valid ? b_q.mag : '0;
  assign b_neg = set_valid && b_q.neg;

  // R2
  zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((a_neg && a_mag == '0) || (b_neg && b_mag == '0)));
  // R9
  sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_s |=> !set_valid);
endmodule

// File: tb/ustep_xlate_tb.sv
module ustep_xlate_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_in = 1'b0, dir_in = 1'b1, home_in = 1'b0;
  logic sleep_n = 1'b1, drive_en = 1'b1;
  logic [1:0] mode_sel = 2'b11;
  logic [7:0] a_mag, b_mag;
  logic a_neg, b_neg, a_mixed, b_mixed, set_valid;
  int total = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ustep_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in),
    .mode_sel(mode_sel), .home_in(home_in), .sleep_n(sleep_n),
    .drive_en(drive_en), .a_mag(a_mag), .a_neg(a_neg), .b_mag(b_mag),
    .b_neg(b_neg), .a_mixed(a_mixed), .b_mixed(b_mixed),
    .set_valid(set_valid));

  // {mode, dir, a_mag, a_neg, b_mag, b_neg, a_mix, b_mix}
  localparam logic [22:0] VEC [NVEC] = '{
    {2'd3,1'b1,8'd142,1'b0,8'd212,1'b0,1'b1,1'b0}, // R3 idx5
    {2'd3,1'b1,8'd98, 1'b0,8'd236,1'b0,1'b1,1'b0}, // R3 idx6
    {2'd3,1'b0,8'd142,1'b0,8'd212,1'b0,1'b0,1'b1}, // R3 back 5
    {2'd3,1'b0,8'd180,1'b0,8'd180,1'b0,1'b0,1'b1}, // 4
    {2'd3,1'b0,8'd212,1'b0,8'd142,1'b0,1'b0,1'b1}, // 3
    {2'd2,1'b1,8'd180,1'b0,8'd180,1'b0,1'b1,1'b0}, // R7 tie up ->4
    {2'd2,1'b1,8'd98, 1'b0,8'd236,1'b0,1'b1,1'b0}, // R4 6
    {2'd2,1'b1,8'd0,  1'b0,8'd255,1'b0,1'b1,1'b0}, // R2 8 zero
    {2'd2,1'b1,8'd98, 1'b1,8'd236,1'b0,1'b0,1'b1}, // 10
    {2'd1,1'b1,8'd180,1'b1,8'd180,1'b0,1'b0,1'b1}, // R7 tie ->12
    {2'd1,1'b1,8'd255,1'b1,8'd0,  1'b0,1'b0,1'b1}, // R4 16
    {2'd3,1'b1,8'd250,1'b1,8'd50, 1'b1,1'b1,1'b0}, // 17
    {2'd0,1'b1,8'd180,1'b1,8'd180,1'b1,1'b1,1'b0}, // R7 snap ->20
    {2'd0,1'b1,8'd180,1'b0,8'd180,1'b1,1'b0,1'b0}, // R5 28
    {2'd0,1'b1,8'd180,1'b0,8'd180,1'b0,1'b0,1'b0}, // R5 wrap ->4
    {2'd0,1'b0,8'd180,1'b0,8'd180,1'b1,1'b0,1'b0}, // R5 wrap ->28
    {2'd3,1'b1,8'd212,1'b0,8'd142,1'b1,1'b0,1'b1}, // 29
    {2'd1,1'b0,8'd180,1'b0,8'd180,1'b1,1'b1,1'b0}, // R7 down ->28
    {2'd3,1'b0,8'd142,1'b0,8'd212,1'b1,1'b1,1'b0}, // 27
    {2'd0,1'b0,8'd180,1'b0,8'd180,1'b1,1'b0,1'b1}, // R7 nearest up ->28
    {2'd3,1'b0,8'd142,1'b0,8'd212,1'b1,1'b1,1'b0}, // 27
    {2'd2,1'b0,8'd98, 1'b0,8'd236,1'b1,1'b1,1'b0}  // R7 tie down ->26
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_pt(input string req, input logic [7:0] am, input logic an,
                        input logic [7:0] bm, input logic bn);
    chk(req, {22'd0, a_mag, a_neg, b_mag, b_neg}, {22'd0, am, an, bm, bn});
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_step(input logic [1:0] m, input logic d);
    mode_sel = m; dir_in = d;
    wait_n(3);
    step_in = 1'b1;
    wait_n(3);
    step_in = 1'b0;
    wait_n(6);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    chk("R1 valid in reset", {31'd0, set_valid}, 32'd0);
    rst_n = 1'b1;
    wait_n(6);
    chk("R1 valid after reset", {31'd0, set_valid}, 32'd1);
    chk_pt("R1 home setpoint", 8'd180, 1'b0, 8'd180, 1'b0);

    // R2 R3 R4 R5 R6 R7 R11 table walk
    for (int i = 0; i < NVEC; i++) begin
      pulse_step(VEC[i][22:21], VEC[i][20]);
      chk($sformatf("R2/R6 vec %0d", i), {22'd0, a_mag, a_neg, b_mag, b_neg},
          {22'd0, VEC[i][19:2]});
      chk($sformatf("R11 vec %0d", i), {30'd0, a_mixed, b_mixed},
          {30'd0, VEC[i][1:0]});
    end

    // R12: held high, then falling edge: one advance only (26 -> 27)
    mode_sel = 2'b11; dir_in = 1'b1;
    wait_n(3);
    step_in = 1'b1;
    wait_n(20);
    chk_pt("R12 held high", 8'd142, 1'b0, 8'd212, 1'b1);
    step_in = 1'b0;
    wait_n(8);
    chk_pt("R12 after fall", 8'd142, 1'b0, 8'd212, 1'b1);

    // R10: disable gates outputs, index still tracks (27 -> 28)
    drive_en = 1'b0;
    wait_n(6);
    chk("R10 valid low", {31'd0, set_valid}, 32'd0);
    chk_pt("R10 gated zero", 8'd0, 1'b0, 8'd0, 1'b0);
    pulse_step(2'b11, 1'b1);
    chk_pt("R10 still gated", 8'd0, 1'b0, 8'd0, 1'b0);
    drive_en = 1'b1;
    wait_n(6);
    chk("R10 valid back", {31'd0, set_valid}, 32'd1);
    chk_pt("R10 tracked index", 8'd180, 1'b0, 8'd180, 1'b1);

    // R8: home request pins index, step ignored
    home_in = 1'b1;
    wait_n(6);
    chk_pt("R8 homed", 8'd180, 1'b0, 8'd180, 1'b0);
    pulse_step(2'b11, 1'b1);
    chk_pt("R8 step ignored", 8'd180, 1'b0, 8'd180, 1'b0);
    home_in = 1'b0;
    wait_n(6);
    chk_pt("R8 released", 8'd180, 1'b0, 8'd180, 1'b0);

    // R9: sleep gates, wake homes
    pulse_step(2'b11, 1'b1);
    chk_pt("R9 pre-sleep step", 8'd142, 1'b0, 8'd212, 1'b0);
    sleep_n = 1'b0;
    wait_n(6);
    chk("R9 asleep valid", {31'd0, set_valid}, 32'd0);
    sleep_n = 1'b1;
    wait_n(6);
    chk("R9 awake valid", {31'd0, set_valid}, 32'd1);
    chk_pt("R9 wake homes", 8'd180, 1'b0, 8'd180, 1'b0);

    // R3 reverse wrap: eighth back from 4 down to 31 then 0->31 crossing
    for (int j = 0; j < 5; j++) pulse_step(2'b11, 1'b0);
    chk_pt("R3 reverse wrap idx31", 8'd250, 1'b0, 8'd50, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule